// File: doc/BRIEF.md
# Static Branch Predictor with Return-Address Stack

This unit sits in the fetch stage. Each cycle it receives one fetched 32-bit instruction, which has already been sorted into a control-flow class, along with the address it was fetched from. In the same cycle it returns a taken/not-taken guess and the next fetch address. Conditional branches are guessed from the direction of their displacement: backward means taken, forward means not taken. Direct jumps and direct calls are always taken. Indirect jumps are followed only when they go through one of the three link registers. Their target then comes from a small stack of return addresses.

Calls push their fall-through address onto the stack and report a write of that address into the return-link register. Returns pop the stack. Every prediction carries a checkpoint of the stack state (occupancy and pointer). If that prediction later turns out wrong, the pipeline drives the flush input with the checkpoint to put the stack back. Resolving the branch itself is done elsewhere.

Top module: `static_branch_predictor`

## Requirements
- R1: For class 1 (conditional branch), the predicted-taken flag equals instruction bit 15. The displacement is instruction bits 14..0 shifted left by two, with bit 15 copied into every bit from 17 upward. A taken target is the fetch address plus that displacement.
- R2: For class 2 (direct jump) and class 3 (direct call), the prediction is always taken. The target is the fetch address plus instruction bits 24..0 shifted left by two, with bit 25 copied into every higher bit.
- R3: For class 4 (indirect jump) whose register field, bits 25..21, is 29, 30 or 31, with all of bits 20..0 zero and a non-empty stack, the prediction is taken. The target is the most recently pushed address, and that entry is popped.
- R4: A class 4 indirect jump through any other register is predicted not taken and leaves the stack unchanged.
- R5: Class 3 and class 5 (indirect call) push fetch address + 4. They also assert the link write with register 29 and value fetch address + 4. Class 5 is predicted not taken.
- R6: Class 4 or 5 with any bit of 20..0 set raises the illegal flag. It is predicted not taken, does not touch the stack and writes no link.
- R7: A return-style jump on an empty stack is predicted not taken, and the stack stays empty.
- R8: The stack holds 8 entries. Pushing onto a full stack overwrites the oldest entry, so the count stays at 8, and eight pops then return the eight newest addresses, newest first.
- R9: When flush is high, the stack count and pointer are loaded from the checkpoint input on that clock edge. Any instruction presented in the same cycle is ignored and all of its prediction outputs are zero.
- R10: After reset the stack is empty: the empty flag is 1 and the full flag is 0. With valid low, the taken, link-write and illegal outputs are 0.
- R11: Whenever the prediction is not taken, the target output is the fall-through address, fetch address + 4. This includes class 0 (not a control transfer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | An instruction is presented this cycle |
| fetch_pc | input | 32 | Address of the instruction |
| kind | input | 3 | Class: 0 other, 1 cond branch, 2 direct jump, 3 direct call, 4 indirect jump, 5 indirect call |
| insn | input | 32 | Instruction word |
| flush | input | 1 | Restore the stack from flush_ckpt |
| flush_ckpt | input | 7 | Checkpoint to restore: {count, pointer} |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | 32 | Predicted next fetch address |
| link_we | output | 1 | Call writes the return link |
| link_reg | output | 5 | Link register index (29) |
| link_value | output | 32 | Value written to the link register |
| illegal | output | 1 | Malformed indirect jump/call |
| ras_empty | output | 1 | Stack holds no entry |
| ras_full | output | 1 | Stack holds DEPTH entries |
| ckpt | output | 7 | Stack state before this instruction: {count, pointer} |

## Verification
The case that is hardest to reach from the ports is a stack that has wrapped. There, the oldest address has been overwritten and the pointer has gone around the storage. The bench reaches it by issuing nine calls in a row, each from a distinct address, and then popping eight times, checking each popped address against the newest eight. A second hard case is recovery. There, a checkpoint is read from the ports in the middle of a call sequence and restored with flush, while a competing call is presented in the same cycle. A following return must then yield the address saved before the checkpoint.

// File: rtl/static_branch_predictor.sv
module static_branch_predictor #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [AW-1:0]        fetch_pc,
  input  logic [2:0]           kind,
  input  logic [31:0]          insn,
  input  logic                 flush,
  input  logic [$clog2(DEPTH+1)+$clog2(DEPTH)-1:0] flush_ckpt,
  output logic                 pred_taken,
  output logic [AW-1:0]        pred_target,
  output logic                 link_we,
  output logic [4:0]           link_reg,
  output logic [AW-1:0]        link_value,
  output logic                 illegal,
  output logic                 ras_empty,
  output logic                 ras_full,
  output logic [$clog2(DEPTH+1)+$clog2(DEPTH)-1:0] ckpt
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [2:0] K_COND = 3'd1, K_DJMP = 3'd2, K_DCALL = 3'd3,
                         K_IJMP = 3'd4, K_ICALL = 3'd5;
  localparam logic [4:0] LINK_RET = 5'd29;

  logic [AW-1:0]    stack_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q;
  logic             live, indirect, malformed, ret_reg, want_pop, do_pop, do_push;
  logic [AW-1:0]    fall, br_disp, jp_disp;

  assign live      = valid && !flush;
  assign indirect  = (kind == K_IJMP) || (kind == K_ICALL);
  assign malformed = indirect && (|insn[20:0]);
  assign ret_reg   = insn[25:21] >= LINK_RET;
  assign want_pop  = live && kind == K_IJMP && !malformed && ret_reg;
  assign do_pop    = want_pop && cnt_q != '0;
  assign do_push   = live && (kind == K_DCALL || (kind == K_ICALL && !malformed));

  assign fall    = fetch_pc + AW'(4);
  assign br_disp = {{(AW-17){insn[15]}}, insn[14:0], 2'b00};
  assign jp_disp = {{(AW-27){insn[25]}}, insn[24:0], 2'b00};

  assign ptr_inc = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? PTR_W'(DEPTH-1) : ptr_q - 1'b1;

  always_comb begin
    pred_taken  = 1'b0;
    pred_target = fall;
    if (live) begin
      unique case (kind)
        K_COND: if (insn[15]) begin
          pred_taken  = 1'b1;
          pred_target = fetch_pc + br_disp;
        end
        K_DJMP, K_DCALL: begin
          pred_taken  = 1'b1;
          pred_target = fetch_pc + jp_disp;
        end
        K_IJMP: if (do_pop) begin
          pred_taken  = 1'b1;
          pred_target = stack_q[ptr_dec];
        end
        default: ;
      endcase
    end
  end

  assign link_we    = do_push;
  assign link_reg   = LINK_RET;
  assign link_value = fall;
  assign illegal    = live && malformed;
  assign ras_empty  = cnt_q == '0;
  assign ras_full   = cnt_q == CNT_W'(DEPTH);
  assign ckpt       = {cnt_q, ptr_q};

  always_ff @(posedge clk) begin
    if (do_push) stack_q[ptr_q] <= fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      {cnt_q, ptr_q} <= flush_ckpt;
    end else if (do_push) begin
      ptr_q <= ptr_inc;
      if (!ras_full) cnt_q <= cnt_q + 1'b1;
    end else if (do_pop) begin
      ptr_q <= ptr_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_full_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we && ras_full && !flush) |=> ras_full);
  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we && !ras_full) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (want_pop && ras_empty) |-> !pred_taken);
  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !flush) |=> ($stable(cnt_q) && $stable(ptr_q)));
  p_flush_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ckpt == $past(flush_ckpt));
  p_cond_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && kind == K_COND) |-> pred_taken == insn[15]);
endmodule

// File: tb/test_static_branch_predictor.sv
module test_static_branch_predictor;
  logic clk = 0, rst_n = 0, valid = 0, flush = 0;
  logic [31:0] fetch_pc = 0, insn = 0;
  logic [2:0] kind = 0;
  logic [6:0] flush_ckpt = 0;
  logic pred_taken, link_we, illegal, ras_empty, ras_full;
  logic [31:0] pred_target, link_value;
  logic [4:0] link_reg;
  logic [6:0] ckpt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  static_branch_predictor i_static_branch_predictor (
    .clk, .rst_n, .valid, .fetch_pc, .kind, .insn, .flush, .flush_ckpt,
    .pred_taken, .pred_target, .link_we, .link_reg, .link_value,
    .illegal, .ras_empty, .ras_full, .ckpt);

  // {kind, pc, insn, taken, target}
  localparam logic [99:0] VEC [8] = '{
    {3'd1, 32'h0000_1000, 32'h0000_FFFC, 1'b1, 32'h0000_0FF0},  // R1 backward
    {3'd1, 32'h0000_1000, 32'h0000_0010, 1'b0, 32'h0000_1004},  // R1 R11 forward
    {3'd1, 32'h0000_1000, 32'h0000_8000, 1'b1, 32'hFFFE_1000},  // R1 most negative
    {3'd2, 32'h0000_8000, 32'h0000_0100, 1'b1, 32'h0000_8400},  // R2 forward
    {3'd2, 32'h0000_1000, 32'h03FF_FFFF, 1'b1, 32'h0000_0FFC},  // R2 negative
    {3'd4, 32'h0000_1000, 32'h00A0_0000, 1'b0, 32'h0000_1004},  // R4 reg 5
    {3'd0, 32'h0000_1000, 32'hFFFF_FFFF, 1'b0, 32'h0000_1004},  // R11 other
    {3'd4, 32'h0000_1000, 32'h03A0_0000, 1'b0, 32'h0000_1004}   // R7 empty pop
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [31:0] pc, input logic [31:0] w);
    @(negedge clk);
    valid = 1; kind = k; fetch_pc = pc; insn = w;
    #1;
  endtask

  task automatic pred(input string req, input bit tk, input logic [31:0] tgt);
    chk(pred_taken == tk, req, {31'd0, pred_taken}, {31'd0, tk});
    chk(pred_target == tgt, req, pred_target, tgt);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [6:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(ras_empty && !ras_full, "R10 reset", {30'd0, ras_empty, ras_full}, 32'h2);
    chk(!pred_taken && !link_we && !illegal, "R10 idle", {29'd0, pred_taken, link_we, illegal}, 0);

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][99:97], VEC[i][96:65], VEC[i][64:33]);
      pred($sformatf("R1/R2/R4/R7/R11 vector %0d", i), VEC[i][32], VEC[i][31:0]);
    end
    @(negedge clk); valid = 0; #1;
    chk(ras_empty, "R7 still empty", {31'd0, ras_empty}, 1);

    // R5 direct call, then R3 return through 29
    drive(3'd3, 32'h100, 32'h0000_0010);
    pred("R5 direct call", 1, 32'h140);
    chk(link_we && link_reg == 29 && link_value == 32'h104, "R5 link", link_value, 32'h104);
    drive(3'd4, 32'h500, 32'h03A0_0000);
    pred("R3 return r29", 1, 32'h104);
    @(negedge clk); valid = 0; #1;
    chk(ras_empty, "R3 popped", {31'd0, ras_empty}, 1);

    // R5 indirect call, R6 illegal, R3 return through 30 and 31
    drive(3'd5, 32'h200, 32'h0060_0000);
    pred("R5 indirect call", 0, 32'h204);
    chk(link_we && link_value == 32'h204, "R5 indirect link", link_value, 32'h204);
    drive(3'd4, 32'h600, 32'h03C0_0001);
    chk(illegal, "R6 illegal flag", {31'd0, illegal}, 1);
    pred("R6 illegal", 0, 32'h604);
    drive(3'd5, 32'h700, 32'h0060_0004);
    chk(illegal && !link_we, "R6 illegal call", {30'd0, illegal, link_we}, 32'h2);
    drive(3'd4, 32'h800, 32'h03C0_0000);
    pred("R3 return r30 after R6", 1, 32'h204);
    drive(3'd5, 32'h220, 32'h0060_0000);
    drive(3'd4, 32'h900, 32'h03E0_0000);
    pred("R3 return r31", 1, 32'h224);
    @(negedge clk); valid = 0; #1;
    chk(ras_empty, "R3 empty again", {31'd0, ras_empty}, 1);

    // R8 overflow: nine calls, eight pops
    for (int i = 0; i < 9; i++) drive(3'd3, 32'h1000 + 16*i, 32'h0);
    @(negedge clk); valid = 0; #1;
    chk(ras_full, "R8 full", {31'd0, ras_full}, 1);
    for (int i = 8; i >= 1; i--) begin
      drive(3'd4, 32'h4000, 32'h03A0_0000);
      pred($sformatf("R8 pop %0d", i), 1, 32'h1004 + 16*i);
    end
    @(negedge clk); valid = 0; #1;
    chk(ras_empty, "R8 drained", {31'd0, ras_empty}, 1);
    drive(3'd4, 32'h4000, 32'h03A0_0000);
    pred("R7 pop after drain", 0, 32'h4004);

    // R9 flush restores checkpoint, same-cycle call ignored
    drive(3'd3, 32'h300, 32'h0);
    drive(3'd0, 32'h310, 32'h0);
    saved = ckpt;
    drive(3'd3, 32'h320, 32'h0);
    drive(3'd3, 32'h330, 32'h0);
    @(negedge clk);
    valid = 1; kind = 3'd3; fetch_pc = 32'h340; insn = 0;
    flush = 1; flush_ckpt = saved;
    #1;
    chk(!link_we && !pred_taken, "R9 flush cycle quiet", {30'd0, link_we, pred_taken}, 0);
    @(negedge clk); flush = 0; valid = 0; #1;
    chk(ckpt == saved, "R9 restored", {25'd0, ckpt}, {25'd0, saved});
    drive(3'd4, 32'h5000, 32'h03A0_0000);
    pred("R9 return after flush", 1, 32'h304);
    @(negedge clk); valid = 0; #1;
    chk(ras_empty, "R9 empty", {31'd0, ras_empty}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule